// File: doc/BRIEF.md
# Multi-Width Integer Register ALU

This block executes two-operand integer operate instructions whose operands and result both sit in 64-bit registers. A 7-bit opcode is split into a 4-bit column and a 3-bit row. The column picks the operand width, and whether the primary or the secondary operation set applies. The row picks the operation within that set. The block receives the current source and destination register values. It returns the value to write into each register, a write enable per register, and a set of condition flags that only the compare operation updates.

Every narrow result is widened back to 64 bits. Arithmetic and logic results are sign-extended, an unsigned load zero-fills, and an insert keeps the upper part of the destination untouched. Opcodes outside the integer columns, and the integer rows this unit does not execute, are reported through an illegal output. In that case neither register nor the flags are written. The surrounding pipeline reads the results one cycle after an accepted request, or in the same cycle when the output register is configured out.

Top module: `mxalu_top`

## Requirements
- R1: The opcode splits into a column (bits 6:3) and a row (bits 2:0). Any column with bit 3 set (columns 1000 to 1111, covering floating-point and reserved codes) reports illegal and writes nothing.
- R2: In columns 0000 to 0111, column bits 2:1 give the width: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit and 3 is 64-bit. Column bit 0 selects the secondary set of operations.
- R3: Primary row 0 (swap) asserts both write enables. The destination receives the source, and the source receives the destination, each sign-extended from the width.
- R4: Primary row 2 (load) writes the source, sign-extended from the width, into the destination.
- R5: Secondary row 2 (unsigned load) writes the low width bits of the source into the destination and clears all the bits above them.
- R6: Secondary row 0 (insert) replaces the low width bits of the destination with those of the source and keeps the upper destination bits.
- R7: Primary rows 4 and 5 compute destination plus source and destination minus source at the width. The result is sign-extended and written to the destination.
- R8: Primary row 3 (xor), secondary row 4 (and) and secondary row 5 (or) produce bitwise results at the width, sign-extended into the destination.
- R9: Primary row 6 (multiply) writes the low width bits of the product, sign-extended, for the 16-, 32- and 64-bit widths. In the 8-bit column this row is illegal.
- R10: Primary row 1 (compare) writes no register and asserts the flag enable. It subtracts the source from the destination, with both sign-extended from the width and one bit wider, so the subtraction cannot overflow. The flags are: bit 0 equal, bit 1 low (signed less), bit 2 high (signed greater), bit 3 carry (unsigned destination below source) and bit 4 overflow, which is always 0.
- R11: Primary row 7, and secondary rows 1, 3, 6 and 7, report illegal and write nothing.
- R12: With the default output register, the results appear on the cycle after the request. Out of reset, and on any cycle without a valid result, out_valid, illegal and all write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 7 | Column (6:3) and row (2:0) |
| src_val | input | 64 | Current source register value |
| dst_val | input | 64 | Current destination register value |
| out_valid | output | 1 | Result present |
| dst_we | output | 1 | Write destination register |
| dst_res | output | 64 | New destination value |
| src_we | output | 1 | Write source register (swap only) |
| src_res | output | 64 | New source value |
| cc_we | output | 1 | Update condition flags |
| cc_flags | output | 5 | {overflow, carry, high, low, equal} |
| illegal | output | 1 | Opcode not executed by this unit |

## Verification
The bench builds the block with its default registered output stage. This makes the one-cycle result latency and the reset values observable. Random opcodes cover the whole 7-bit space, so the floating-point, reserved and unimplemented integer codes occur alongside every width of every executed operation. The operand patterns include equal low parts and the most negative value. These patterns reach the equal flag and the compare case where a plain subtraction would overflow.

// File: rtl/mxalu_pkg.sv
package mxalu_pkg;

    localparam int XLEN  = 64;
    localparam int OPC_W = 7;
    localparam int ROW_W = 3;
    localparam int COL_W = OPC_W - ROW_W;
    localparam int CC_W  = 5;

    typedef enum logic [1:0] {SZ_B, SZ_H, SZ_W, SZ_L} size_e;

    typedef enum logic [3:0] {
        OP_SWAP, OP_CMP, OP_LD, OP_XOR, OP_ADD, OP_SUB, OP_MUL,
        OP_INS, OP_ULD, OP_AND, OP_OR, OP_BAD
    } op_e;

    typedef struct packed {
        op_e   op;
        size_e size;
        logic  bad;
    } dec_t;

    // bit 0 eq, 1 low, 2 high, 3 carry, 4 overflow
    typedef struct packed {
        logic ovf;
        logic carry;
        logic high;
        logic low;
        logic eq;
    } cc_t;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] dst;
        logic [XLEN-1:0] src;
        logic            dst_we;
        logic            src_we;
        logic            cc_we;
        cc_t             cc;
        logic            bad;
    } res_t;

    function automatic logic [XLEN-1:0] low_mask(input size_e sz);
        case (sz)
            SZ_B:    return {{(XLEN-8){1'b0}},  {8{1'b1}}};
            SZ_H:    return {{(XLEN-16){1'b0}}, {16{1'b1}}};
            SZ_W:    return {{(XLEN-32){1'b0}}, {32{1'b1}}};
            default: return {XLEN{1'b1}};
        endcase
    endfunction

    function automatic logic [XLEN-1:0] sext_sz(input logic [XLEN-1:0] v, input size_e sz);
        case (sz)
            SZ_B:    return {{(XLEN-8){v[7]}},   v[7:0]};
            SZ_H:    return {{(XLEN-16){v[15]}}, v[15:0]};
            SZ_W:    return {{(XLEN-32){v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/mxalu_decode.sv
module mxalu_decode
    import mxalu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic             alt_set;

    assign col     = opcode[OPC_W-1:ROW_W];
    assign row     = opcode[ROW_W-1:0];
    assign alt_set = col[0];

    always_comb begin
        dec.size = size_e'(col[2:1]);
        dec.op   = OP_BAD;
        if (!col[COL_W-1]) begin
            if (!alt_set) begin
                case (row)
                    3'd0: dec.op = OP_SWAP;
                    3'd1: dec.op = OP_CMP;
                    3'd2: dec.op = OP_LD;
                    3'd3: dec.op = OP_XOR;
                    3'd4: dec.op = OP_ADD;
                    3'd5: dec.op = OP_SUB;
                    3'd6: dec.op = (col[2:1] == SZ_B) ? OP_BAD : OP_MUL;
                    default: dec.op = OP_BAD;
                endcase
            end else begin
                case (row)
                    3'd0: dec.op = OP_INS;
                    3'd2: dec.op = OP_ULD;
                    3'd4: dec.op = OP_AND;
                    3'd5: dec.op = OP_OR;
                    default: dec.op = OP_BAD;
                endcase
            end
        end
        dec.bad = (dec.op == OP_BAD);
    end

endmodule

// File: rtl/mxalu_exec.sv
module mxalu_exec
    import mxalu_pkg::*;
(
    input  dec_t            dec,
    input  logic [XLEN-1:0] dst_in,
    input  logic [XLEN-1:0] src_in,
    output logic [XLEN-1:0] dst_out,
    output logic [XLEN-1:0] src_out,
    output logic            dst_we,
    output logic            src_we
);
    logic [XLEN-1:0] msk;
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] dif;
    logic [XLEN-1:0] prod;

    assign msk  = low_mask(dec.size);
    assign sum  = dst_in + src_in;
    assign dif  = dst_in - src_in;
    assign prod = dst_in * src_in;

    always_comb begin
        dst_out = dst_in;
        src_out = src_in;
        dst_we  = 1'b0;
        src_we  = 1'b0;
        case (dec.op)
            OP_SWAP: begin
                dst_out = sext_sz(src_in, dec.size);
                src_out = sext_sz(dst_in, dec.size);
                dst_we  = 1'b1;
                src_we  = 1'b1;
            end
            OP_LD: begin
                dst_out = sext_sz(src_in, dec.size);
                dst_we  = 1'b1;
            end
            OP_ULD: begin
                dst_out = src_in & msk;
                dst_we  = 1'b1;
            end
            OP_INS: begin
                dst_out = (dst_in & ~msk) | (src_in & msk);
                dst_we  = 1'b1;
            end
            OP_XOR: begin
                dst_out = sext_sz(dst_in ^ src_in, dec.size);
                dst_we  = 1'b1;
            end
            OP_AND: begin
                dst_out = sext_sz(dst_in & src_in, dec.size);
                dst_we  = 1'b1;
            end
            OP_OR: begin
                dst_out = sext_sz(dst_in | src_in, dec.size);
                dst_we  = 1'b1;
            end
            OP_ADD: begin
                dst_out = sext_sz(sum, dec.size);
                dst_we  = 1'b1;
            end
            OP_SUB: begin
                dst_out = sext_sz(dif, dec.size);
                dst_we  = 1'b1;
            end
            OP_MUL: begin
                dst_out = sext_sz(prod, dec.size);
                dst_we  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mxalu_cmp.sv
module mxalu_cmp
    import mxalu_pkg::*;
(
    input  size_e           size,
    input  logic [XLEN-1:0] dst_in,
    input  logic [XLEN-1:0] src_in,
    output cc_t             cc
);
    localparam int WIDE = XLEN + 1;

    logic [XLEN-1:0] a_sx;
    logic [XLEN-1:0] b_sx;
    logic [WIDE-1:0] a_w;
    logic [WIDE-1:0] b_w;
    logic [WIDE-1:0] diff;
    logic [XLEN-1:0] msk;

    assign a_sx = sext_sz(dst_in, size);
    assign b_sx = sext_sz(src_in, size);
    assign a_w  = {a_sx[XLEN-1], a_sx};
    assign b_w  = {b_sx[XLEN-1], b_sx};
    assign diff = a_w - b_w;
    assign msk  = low_mask(size);

    always_comb begin
        cc.eq    = (diff == '0);
        cc.low   = diff[WIDE-1];
        cc.high  = !cc.eq && !cc.low;
        cc.carry = (dst_in & msk) < (src_in & msk);
        cc.ovf   = 1'b0;
    end

endmodule

// File: rtl/mxalu_top.sv
module mxalu_top
    import mxalu_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic [XLEN-1:0]  src_val,
    input  logic [XLEN-1:0]  dst_val,
    output logic             out_valid,
    output logic             dst_we,
    output logic [XLEN-1:0]  dst_res,
    output logic             src_we,
    output logic [XLEN-1:0]  src_res,
    output logic             cc_we,
    output logic [CC_W-1:0]  cc_flags,
    output logic             illegal
);
    dec_t            dec;
    logic [XLEN-1:0] ex_dst;
    logic [XLEN-1:0] ex_src;
    logic            ex_dst_we;
    logic            ex_src_we;
    cc_t             cmp_cc;
    res_t            res_c;
    res_t            res_q;

    mxalu_decode u_decode (
        .opcode (opcode),
        .dec    (dec)
    );

    mxalu_exec u_exec (
        .dec     (dec),
        .dst_in  (dst_val),
        .src_in  (src_val),
        .dst_out (ex_dst),
        .src_out (ex_src),
        .dst_we  (ex_dst_we),
        .src_we  (ex_src_we)
    );

    mxalu_cmp u_cmp (
        .size   (dec.size),
        .dst_in (dst_val),
        .src_in (src_val),
        .cc     (cmp_cc)
    );

    always_comb begin
        res_c = '0;
        if (in_valid) begin
            res_c.vld    = 1'b1;
            res_c.dst    = ex_dst;
            res_c.src    = ex_src;
            res_c.dst_we = ex_dst_we;
            res_c.src_we = ex_src_we;
            res_c.cc_we  = (dec.op == OP_CMP);
            res_c.cc     = cmp_cc;
            res_c.bad    = dec.bad;
        end
    end

    generate
        if (OUT_REG) begin : g_out_reg
            always_ff @(posedge clk) begin
                if (rst) res_q <= '0;
                else     res_q <= res_c;
            end

            AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid); // R12
        end else begin : g_out_comb
            assign res_q = res_c;
        end
    endgenerate

    assign out_valid = res_q.vld;
    assign dst_we    = res_q.dst_we;
    assign dst_res   = res_q.dst;
    assign src_we    = res_q.src_we;
    assign src_res   = res_q.src;
    assign cc_we     = res_q.cc_we;
    assign cc_flags  = res_q.cc;
    assign illegal   = res_q.bad;

    AST_CMP_NO_REG_WRITE: assert property (@(posedge clk) disable iff (rst)
        cc_we |-> (!dst_we && !src_we)); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cc_we |-> !cc_flags[4]); // R10
    AST_ONE_ORDER_FLAG: assert property (@(posedge clk) disable iff (rst)
        cc_we |-> ($countones(cc_flags[2:0]) == 1)); // R10
    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !(dst_we || src_we || cc_we)); // R11
    AST_SRC_WRITE_PAIRED: assert property (@(posedge clk) disable iff (rst)
        src_we |-> dst_we); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(dst_we || src_we || cc_we || illegal)); // R12

endmodule

// File: tb/mxalu_top_tb.sv
module mxalu_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [6:0]  opcode;
    logic [63:0] src_val;
    logic [63:0] dst_val;
    logic        out_valid;
    logic        dst_we;
    logic [63:0] dst_res;
    logic        src_we;
    logic [63:0] src_res;
    logic        cc_we;
    logic [4:0]  cc_flags;
    logic        illegal;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    mxalu_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .src_val   (src_val),
        .dst_val   (dst_val),
        .out_valid (out_valid),
        .dst_we    (dst_we),
        .dst_res   (dst_res),
        .src_we    (src_we),
        .src_res   (src_res),
        .cc_we     (cc_we),
        .cc_flags  (cc_flags),
        .illegal   (illegal)
    );

    function automatic logic [63:0] sx(input logic [63:0] v, input int w);
        int sh;
        sh = 64 - w;
        return 64'($signed(v << sh) >>> sh);
    endfunction

    function automatic logic [63:0] zx(input logic [63:0] v, input int w);
        int sh;
        sh = 64 - w;
        return (v << sh) >> sh;
    endfunction

    function automatic string tag_of(input logic [6:0] opc);
        logic [3:0] col;
        logic [2:0] row;
        col = opc[6:3];
        row = opc[2:0];
        if (col[3]) return "R1";
        if (!col[0]) begin
            case (row)
                3'd0: return "R3";
                3'd1: return "R10";
                3'd2: return "R4";
                3'd3: return "R8";
                3'd4, 3'd5: return "R7";
                3'd6: return "R9";
                default: return "R11";
            endcase
        end
        case (row)
            3'd0: return "R6";
            3'd2: return "R5";
            3'd4, 3'd5: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic model(input logic [6:0] opc, input logic [63:0] d, input logic [63:0] s,
                         output logic [63:0] ed, output logic [63:0] es,
                         output logic ewd, output logic ews, output logic ewc,
                         output logic [4:0] ecc, output logic eill);
        logic [3:0]  col;
        logic [2:0]  row;
        int          w;
        logic [63:0] m;
        logic [63:0] sd;
        logic [63:0] ss;
        logic        eq;
        logic        lo;
        col = opc[6:3];
        row = opc[2:0];
        w   = 8 << col[2:1];
        m   = zx({64{1'b1}}, w);
        ed = 64'h0; es = 64'h0; ewd = 0; ews = 0; ewc = 0; ecc = 5'h0; eill = 0;
        if (col[3]) begin
            eill = 1;
        end else if (!col[0]) begin
            case (row)
                3'd0: begin ed = sx(s, w); es = sx(d, w); ewd = 1; ews = 1; end
                3'd1: begin
                    sd = sx(d, w);
                    ss = sx(s, w);
                    eq = (sd == ss);
                    lo = ($signed(sd) < $signed(ss));
                    ewc = 1;
                    ecc = {1'b0, (zx(d, w) < zx(s, w)), !eq && !lo, lo, eq};
                end
                3'd2: begin ed = sx(s, w); ewd = 1; end
                3'd3: begin ed = sx(d ^ s, w); ewd = 1; end
                3'd4: begin ed = sx(d + s, w); ewd = 1; end
                3'd5: begin ed = sx(d - s, w); ewd = 1; end
                3'd6: begin
                    if (w == 8) eill = 1;
                    else begin ed = sx(d * s, w); ewd = 1; end
                end
                default: eill = 1;
            endcase
        end else begin
            case (row)
                3'd0: begin ed = (d & ~m) | (s & m); ewd = 1; end
                3'd2: begin ed = s & m; ewd = 1; end
                3'd4: begin ed = sx(d & s, w); ewd = 1; end
                3'd5: begin ed = sx(d | s, w); ewd = 1; end
                default: eill = 1;
            endcase
        end
    endtask

    task automatic run_op(input logic [6:0] opc, input logic [63:0] d, input logic [63:0] s);
        logic [63:0] ed;
        logic [63:0] es;
        logic        ewd;
        logic        ews;
        logic        ewc;
        logic [4:0]  ecc;
        logic        eill;
        bit          bad;
        string       tg;
        model(opc, d, s, ed, es, ewd, ews, ewc, ecc, eill);
        tg       = tag_of(opc);
        in_valid = 1'b1;
        opcode   = opc;
        dst_val  = d;
        src_val  = s;
        @(negedge clk);
        in_valid = 1'b0;
        bad = (out_valid !== 1'b1) || (dst_we !== ewd) || (src_we !== ews) ||
              (cc_we !== ewc) || (illegal !== eill) ||
              (ewd && dst_res !== ed) || (ews && src_res !== es) ||
              (ewc && cc_flags !== ecc);
        n_checks++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s op=%02h d=%016h s=%016h got v=%b dwe=%b swe=%b cwe=%b ill=%b dst=%016h src=%016h cc=%05b exp v=1 dwe=%b swe=%b cwe=%b ill=%b dst=%016h src=%016h cc=%05b",
                     tg, opc, d, s, out_valid, dst_we, src_we, cc_we, illegal,
                     dst_res, src_res, cc_flags, ewd, ews, ewc, eill, ed, es, ecc);
        end
    endtask

    task automatic check_idle(input string tg);
        n_checks++;
        if (out_valid !== 1'b0 || dst_we !== 1'b0 || src_we !== 1'b0 ||
            cc_we !== 1'b0 || illegal !== 1'b0) begin
            n_fail++;
            $display("FAIL %s idle got v=%b dwe=%b swe=%b cwe=%b ill=%b exp all 0",
                     tg, out_valid, dst_we, src_we, cc_we, illegal);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed_init;
        logic [63:0] d;
        logic [63:0] s;
        seed_init = $urandom(32'h5EED_0042);
        rst = 1'b1; in_valid = 1'b0; opcode = '0; src_val = '0; dst_val = '0;
        repeat (3) @(negedge clk);
        check_idle("R12"); // reset state
        rst = 1'b0;
        @(negedge clk);
        check_idle("R12");

        // R10: 64-bit compare at the most negative value: low, no overflow, no carry
        run_op(7'h31, 64'h8000_0000_0000_0000, 64'h1);
        // R10: byte compare with equal low parts, different upper parts
        run_op(7'h01, 64'h1234_5678_9ABC_DE55, 64'hFFFF_0000_0000_0055);
        // R10: unsigned below, signed above
        run_op(7'h11, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_FFFF);
        // R6: byte insert keeps upper destination bits
        run_op(7'h08, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0012);
        // R5: halfword unsigned load clears upper bits
        run_op(7'h1A, 64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_8001);
        // R4: 32-bit load sign-extends
        run_op(7'h22, 64'h0, 64'h0000_0000_8000_0000);
        // R3: 32-bit swap
        run_op(7'h20, 64'h1111_1111_F000_0001, 64'h2222_2222_7000_0002);
        // R7: byte add wraps and sign-extends
        run_op(7'h04, 64'h7F, 64'h01);
        // R9: byte multiply is illegal; halfword multiply
        run_op(7'h06, 64'h3, 64'h5);
        run_op(7'h16, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0080);
        // R1: floating-point and reserved columns
        run_op(7'h40, 64'h1, 64'h2);
        run_op(7'h7F, 64'h1, 64'h2);
        // R11: divide and empty secondary rows
        run_op(7'h37, 64'h10, 64'h2);
        run_op(7'h09, 64'h10, 64'h2);
        run_op(7'h3E, 64'h10, 64'h2);
        // R12: no request, quiet outputs
        @(negedge clk);
        check_idle("R12");

        // R2 and all rows: random opcodes over the full space
        for (int i = 0; i < 4000; i++) begin
            int unsigned pat;
            pat = $urandom_range(0, 7);
            d = {$urandom, $urandom};
            s = {$urandom, $urandom};
            if (pat == 0) s = d ^ {$urandom, 32'h0};
            if (pat == 1) d = 64'h8000_0000_0000_0000;
            if (pat == 2) s = 64'hFFFF_FFFF_FFFF_FFFF;
            run_op(7'($urandom_range(0, 127)), d, s);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule